// File: doc/BRIEF.md
# Logic, Compare and Bit-Test Unit

This is a purely combinational execution slice for the read-type, non-arithmetic operations of an accumulator/index processor. It performs bitwise AND, OR and XOR against the accumulator, loads into any of the three registers (A, X, Y), compares a register with a memory operand, and runs a bit test of memory against the accumulator. A width input selects 8-bit or 16-bit operation.

The surrounding core supplies the operation code, the current A, X and Y values and the fetched memory operand. The unit returns the data to write, a select that names the target register (or none), and a value plus an update enable for each of the N, V, Z and C flags. The flag register itself lives outside. So does operand fetch. A flag whose enable is low keeps its old value in that register.

Top module: `lcbUnit`

## Requirements
- R1: Op codes 0 (AND), 1 (OR) and 2 (XOR) combine A with the memory operand and write the result to A (wrSel=1). They update only N and Z: N is the top bit of the result and Z is set when the result is zero.
- R2: Op codes 3, 4 and 5 load the memory operand into A, X or Y (wrSel=1, 2, 3). They update only N and Z, both taken from the loaded value.
- R3: Op codes 6, 7 and 8 compare A, X or Y with the operand. They write nothing (wrSel=0) and update N, Z and C. N is the top bit of (register minus operand) and Z is set when that difference is zero within the active width.
- R4: On a compare, C is 1 exactly when the register is greater than or equal to the operand as an unsigned number of the active width.
- R5: Op code 9 (bit test) writes nothing and updates N, V and Z. N is the operand's top bit (bit 15 wide, bit 7 narrow). V is the bit just below it (bit 14 or 6). Z is set when (operand AND A) is zero within the active width. C is not updated.
- R6: With wide=0 only the low 8 bits take part. On a write, bits 15:8 of wrData equal the target register's current upper byte.
- R7: An update enable is low for every flag the operation does not affect, and that flag's value output is then 0. Op codes 10 to 15 write nothing and raise no enable.
- R8: With wide=1 all 16 bits take part, and N/V come from bits 15 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation code (encoding in R1 to R7) |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| regA | input | 16 | Accumulator value |
| regX | input | 16 | X index value |
| regY | input | 16 | Y index value |
| memOp | input | 16 | Memory operand |
| wrData | output | 16 | Data for the target register |
| wrSel | output | 2 | Target: 0 none, 1 A, 2 X, 3 Y |
| flagN | output | 1 | Negative flag value |
| flagV | output | 1 | Overflow flag value |
| flagZ | output | 1 | Zero flag value |
| flagC | output | 1 | Carry flag value |
| updN | output | 1 | Update enable for N |
| updV | output | 1 | Update enable for V |
| updZ | output | 1 | Update enable for Z |
| updC | output | 1 | Update enable for C |

## Verification
A narrow write produces two results in the same evaluation: the upper byte of the target register is merged back into wrData, and N and Z are derived from the low byte alone. The bench triggers this with narrow loads into X and Y, and with narrow logic ops, using registers whose upper byte has bit 7 set and low-byte results that are zero or negative. Both the merged word and the flags are then compared against an independent model, so a flag computed from the full 16 bits, or an upper byte taken from the wrong register, shows up as a mismatch.

// File: rtl/lcbPkg.sv
package lcbPkg;
  localparam int DATA_W = 16;
  localparam int HALF_W = 8;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_LDA  = 4'd3,
    OP_LDX  = 4'd4,
    OP_LDY  = 4'd5,
    OP_CMPA = 4'd6,
    OP_CMPX = 4'd7,
    OP_CMPY = 4'd8,
    OP_BIT  = 4'd9
  } opCode_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_X    = 2'd2,
    SEL_Y    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    LK_AND  = 2'd0,
    LK_OR   = 2'd1,
    LK_XOR  = 2'd2,
    LK_PASS = 2'd3
  } logicKind_e;

  typedef struct packed {
    regSel_e    tgtSel;
    regSel_e    srcSel;
    logicKind_e logicKind;
    logic       isWrite;
    logic       isCompare;
    logic       isBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/lcbControl.sv
module lcbControl
  import lcbPkg::*;
(
  input  logic [3:0]   opCode,
  output ctrlStrobes_t ctrl
);
  always_comb begin
    ctrl = '{tgtSel: SEL_NONE, srcSel: SEL_A, logicKind: LK_PASS,
             isWrite: 1'b0, isCompare: 1'b0, isBit: 1'b0};
    case (opCode)
      OP_AND:  begin ctrl.tgtSel = SEL_A; ctrl.logicKind = LK_AND; ctrl.isWrite = 1'b1; end
      OP_OR:   begin ctrl.tgtSel = SEL_A; ctrl.logicKind = LK_OR;  ctrl.isWrite = 1'b1; end
      OP_XOR:  begin ctrl.tgtSel = SEL_A; ctrl.logicKind = LK_XOR; ctrl.isWrite = 1'b1; end
      OP_LDA:  begin ctrl.tgtSel = SEL_A; ctrl.isWrite = 1'b1; end
      OP_LDX:  begin ctrl.tgtSel = SEL_X; ctrl.isWrite = 1'b1; end
      OP_LDY:  begin ctrl.tgtSel = SEL_Y; ctrl.isWrite = 1'b1; end
      OP_CMPA: begin ctrl.srcSel = SEL_A; ctrl.isCompare = 1'b1; end
      OP_CMPX: begin ctrl.srcSel = SEL_X; ctrl.isCompare = 1'b1; end
      OP_CMPY: begin ctrl.srcSel = SEL_Y; ctrl.isCompare = 1'b1; end
      OP_BIT:  begin ctrl.isBit = 1'b1; end
      default: ;
    endcase
  end

  // R7: at most one class of operation is active, and only writers name a target
  always_comb begin
    a_r7_one_class: assert ($countones({ctrl.isWrite, ctrl.isCompare, ctrl.isBit}) <= 1);
    a_r3_no_target: assert (ctrl.isWrite || ctrl.tgtSel == SEL_NONE);
  end
endmodule

// File: rtl/lcbDatapath.sv
module lcbDatapath
  import lcbPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W
) (
  input  ctrlStrobes_t  ctrl,
  input  logic          wide,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regX,
  input  logic [DW-1:0] regY,
  input  logic [DW-1:0] memOp,
  output logic [DW-1:0] wrData,
  output logic [1:0]    wrSel,
  output logic          flagN,
  output logic          flagV,
  output logic          flagZ,
  output logic          flagC,
  output logic          updN,
  output logic          updV,
  output logic          updZ,
  output logic          updC
);
  localparam int UPPER_W = DW - HW;

  logic [DW-1:0] widthMask;
  logic [DW-1:0] srcVal;
  logic [DW-1:0] tgtOld;
  logic [DW-1:0] logicRes;
  logic [DW-1:0] maskedRes;
  logic [DW:0]   diffVal;
  logic [DW-1:0] bitAnd;
  logic          resTop;
  logic          diffTop;
  logic          memTop;
  logic          memNext;

  assign widthMask = wide ? {DW{1'b1}} : {{UPPER_W{1'b0}}, {HW{1'b1}}};

  always_comb begin
    case (ctrl.srcSel)
      SEL_X:   srcVal = regX;
      SEL_Y:   srcVal = regY;
      default: srcVal = regA;
    endcase
    case (ctrl.tgtSel)
      SEL_X:   tgtOld = regX;
      SEL_Y:   tgtOld = regY;
      default: tgtOld = regA;
    endcase
  end

  always_comb begin
    case (ctrl.logicKind)
      LK_AND:  logicRes = regA & memOp;
      LK_OR:   logicRes = regA | memOp;
      LK_XOR:  logicRes = regA ^ memOp;
      default: logicRes = memOp;
    endcase
  end

  assign maskedRes = logicRes & widthMask;
  assign diffVal   = {1'b0, srcVal & widthMask} - {1'b0, memOp & widthMask};
  assign bitAnd    = memOp & regA & widthMask;

  assign resTop  = wide ? maskedRes[DW-1]   : maskedRes[HW-1];
  assign diffTop = wide ? diffVal[DW-1]     : diffVal[HW-1];
  assign memTop  = wide ? memOp[DW-1]       : memOp[HW-1];
  assign memNext = wide ? memOp[DW-2]       : memOp[HW-2];

  always_comb begin
    wrSel  = ctrl.isWrite ? ctrl.tgtSel : SEL_NONE;
    wrData = ctrl.isWrite ? ((tgtOld & ~widthMask) | maskedRes) : '0;

    updN = ctrl.isWrite | ctrl.isCompare | ctrl.isBit;
    updZ = updN;
    updV = ctrl.isBit;
    updC = ctrl.isCompare;

    flagN = 1'b0;
    flagZ = 1'b0;
    flagV = 1'b0;
    flagC = 1'b0;
    if (ctrl.isWrite) begin
      flagN = resTop;
      flagZ = (maskedRes == '0);
    end else if (ctrl.isCompare) begin
      flagN = diffTop;
      flagZ = ((diffVal[DW-1:0] & widthMask) == '0);
      flagC = ~diffVal[DW];
    end else if (ctrl.isBit) begin
      flagN = memTop;
      flagV = memNext;
      flagZ = (bitAnd == '0);
    end
  end

  // Checks against the strobes from the control module
  always_comb begin
    a_r7_flag_quiet: assert ((updV || !flagV) && (updC || !flagC)
                             && (updN || !flagN) && (updZ || !flagZ));
    a_r3_compare_no_write: assert (!ctrl.isCompare || wrSel == SEL_NONE);
    a_r5_bit_no_carry: assert (!ctrl.isBit || (!updC && wrSel == SEL_NONE));
    a_r6_upper_kept: assert (wide || !ctrl.isWrite
                             || wrData[DW-1:HW] == tgtOld[DW-1:HW]);
    a_r1_write_flags: assert (!ctrl.isWrite || (updN && updZ && !updV && !updC));
  end
endmodule

// File: rtl/lcbUnit.sv
module lcbUnit
  import lcbPkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        wide,
  input  logic [15:0] regA,
  input  logic [15:0] regX,
  input  logic [15:0] regY,
  input  logic [15:0] memOp,
  output logic [15:0] wrData,
  output logic [1:0]  wrSel,
  output logic        flagN,
  output logic        flagV,
  output logic        flagZ,
  output logic        flagC,
  output logic        updN,
  output logic        updV,
  output logic        updZ,
  output logic        updC
);
  ctrlStrobes_t ctrl;

  lcbControl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  lcbDatapath #(.DW(DATA_W), .HW(HALF_W)) uPath (
    .ctrl   (ctrl),
    .wide   (wide),
    .regA   (regA),
    .regX   (regX),
    .regY   (regY),
    .memOp  (memOp),
    .wrData (wrData),
    .wrSel  (wrSel),
    .flagN  (flagN),
    .flagV  (flagV),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .updN   (updN),
    .updV   (updV),
    .updZ   (updZ),
    .updC   (updC)
  );
endmodule

// File: tb/lcbUnit_test.sv
module lcbUnit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  opCode;
  logic        wide;
  logic [15:0] regA, regX, regY, memOp;
  logic [15:0] wrData;
  logic [1:0]  wrSel;
  logic flagN, flagV, flagZ, flagC, updN, updV, updZ, updC;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  lcbUnit uut (.*);

  // Expected outputs packed as {wrData, wrSel, N,V,Z,C, uN,uV,uZ,uC}
  function automatic logic [25:0] model(input int op, input bit w,
      input int a, input int x, input int y, input int m);
    int mask, top, res, old, src, d;
    logic [15:0] wd; logic [1:0] ws;
    logic n, v, z, c, un, uv, uz, uc;
    mask = w ? 32'hFFFF : 32'hFF;
    top  = w ? 15 : 7;
    wd = 0; ws = 0; n = 0; v = 0; z = 0; c = 0; un = 0; uv = 0; uz = 0; uc = 0;
    if (op <= 5) begin
      case (op)
        0: res = a & m;
        1: res = a | m;
        2: res = a ^ m;
        default: res = m;
      endcase
      res = res & mask;
      ws = (op == 4) ? 2'd2 : (op == 5) ? 2'd3 : 2'd1;
      old = (op == 4) ? x : (op == 5) ? y : a;
      wd = 16'((old & ~mask & 32'hFFFF) | res);
      n = res[top]; z = (res == 0); un = 1; uz = 1;
    end else if (op <= 8) begin
      src = (op == 6) ? a : (op == 7) ? x : y;
      src = src & mask;
      d = src - (m & mask);
      n = d[top]; z = ((d & mask) == 0); c = (src >= (m & mask));
      un = 1; uz = 1; uc = 1;
    end else if (op == 9) begin
      n = m[top]; v = m[top-1]; z = ((m & a & mask) == 0);
      un = 1; uv = 1; uz = 1;
    end
    return {wd, ws, n, v, z, c, un, uv, uz, uc};
  endfunction

  task automatic runCase(input string req, input int op, input bit w,
      input int a, input int x, input int y, input int m);
    logic [25:0] exp, got;
    @(posedge clk);
    opCode = 4'(op); wide = w;
    regA = 16'(a); regX = 16'(x); regY = 16'(y); memOp = 16'(m);
    @(negedge clk);
    exp = model(op, w, a, x, y, m);
    got = {wrData, wrSel, flagN, flagV, flagZ, flagC, updN, updV, updZ, updC};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0d actual=%h expected=%h", req, op, w, got, exp);
    end
  endtask

  task automatic testReset();      // R7 idle state: code 15 everything quiet
    runCase("R7", 15, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    runCase("R7", 10, 0, 16'h1234, 16'h0, 16'h0, 16'h00C0);
  endtask

  task automatic testLogic();      // R1 / R8
    runCase("R1", 0, 1, 16'hF0F0, 0, 0, 16'h0F0F);
    runCase("R1", 1, 1, 16'h8000, 0, 0, 16'h0001);
    runCase("R1", 2, 1, 16'h5A5A, 0, 0, 16'h5A5A);
    runCase("R8", 0, 1, 16'hC3C3, 0, 0, 16'h8181);
  endtask

  task automatic testLoad();       // R2
    runCase("R2", 3, 1, 16'h1111, 0, 0, 16'h8001);
    runCase("R2", 4, 1, 0, 16'h2222, 0, 16'h0000);
    runCase("R2", 5, 1, 0, 0, 16'h3333, 16'h7FFF);
  endtask

  task automatic testCompare();    // R3 / R4
    runCase("R3", 6, 1, 16'h1234, 0, 0, 16'h1234);
    runCase("R4", 7, 1, 0, 16'h0001, 0, 16'h0002);
    runCase("R4", 8, 1, 0, 0, 16'hFFFF, 16'h0001);
    runCase("R4", 6, 0, 16'hAB10, 0, 0, 16'h0020);
    runCase("R4", 7, 0, 0, 16'h0080, 0, 16'hFF7F);
  endtask

  task automatic testBit();        // R5 / R8
    runCase("R5", 9, 1, 16'h0001, 0, 0, 16'hC000);
    runCase("R5", 9, 0, 16'hFF00, 0, 0, 16'h0040);
    runCase("R8", 9, 1, 16'h4000, 0, 0, 16'h4080);
  endtask

  task automatic testNarrow();     // R6: upper byte merge plus low-byte flags
    runCase("R6", 4, 0, 0, 16'hBE12, 0, 16'h0080);
    runCase("R6", 5, 0, 0, 0, 16'h8855, 16'h7700);
    runCase("R6", 0, 0, 16'hF00F, 0, 0, 16'hFFF0);
    runCase("R6", 2, 0, 16'h9981, 0, 0, 16'h0001);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    opCode = 4'd15; wide = 1'b0; regA = 0; regX = 0; regY = 0; memOp = 0;
    testReset();
    testLogic();
    testLoad();
    testCompare();
    testBit();
    testNarrow();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule